// File: doc/BRIEF.md
# 8-bit CPU register file

This block holds the registers that software can see in a small 8-bit processor core. There is an accumulator and two index registers, X and Y. There is an 8-bit stack pointer, a 16-bit program counter and an 8-bit status word. The decoder drives a small set of commands each cycle. Index register commands load, step or compare. Stack commands push, pop or set the pointer from X. Program counter commands load or advance it. A masked port writes status flags. Every register updates on the rising clock edge.

Y and the accumulator can also be read and written together as one 16-bit value. Y is the high byte. The stack lives in a fixed page: the upper byte of the stack address is always zero. A push uses the current pointer and then moves it down. A pop moves the pointer up and uses the new value. The stack address output is combinational, so the memory sees it in the same cycle as the command.

Top module: `core_regfile`

## Requirements
- R1: While reset is high, the program counter becomes FFFEH and A, X, Y and the status word become 00H. The stack pointer has no reset value.
- R2: An index command is encoded 0 nop, 1 load operand, 2 increment, 3 decrement, 4 compare. Increment and decrement wrap modulo 256.
- R3: On compare, the register keeps its value and only three status bits change. Z (bit 1) is set when register and operand are equal. N (bit 7) is bit 7 of register minus operand. C (bit 0) is set when the subtraction needs no borrow. When X and Y compare in the same cycle, X sets the flags.
- R4: The status word holds N, V, D, B, H, I, Z and C at bits 7 down to 0. The flag port writes only the bits set in flag_we. A compare in the same cycle overrides the N, Z and C bits.
- R5: The stack pointer is written only by sp_load, which copies X. Priority runs sp_load, then push, then pop.
- R6: During a push, stk_addr is {00H, SP}. After the edge SP is one lower, and 00H becomes FFH.
- R7: During a pop, stk_addr is {00H, SP+1}. After the edge SP is one higher, and FFH becomes 00H.
- R8: The upper byte of stk_addr is always 00H.
- R9: ya_q is always {Y, A}. ya_we loads both bytes in one cycle. In that cycle a_we and any Y load, increment or decrement are ignored.
- R10: pc_load has priority over pc_inc. An increment wraps FFFFH to 0000H.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rst | input | 1 | synchronous active-high reset |
| a_we | input | 1 | accumulator write enable |
| a_wdata | input | 8 | accumulator write data |
| x_cmd | input | 3 | X register command |
| x_opnd | input | 8 | X load or compare operand |
| y_cmd | input | 3 | Y register command |
| y_opnd | input | 8 | Y load or compare operand |
| ya_we | input | 1 | paired Y:A write enable |
| ya_wdata | input | 16 | paired write data, Y high |
| sp_load | input | 1 | copy X into stack pointer |
| push | input | 1 | push command |
| pop | input | 1 | pop command |
| pc_load | input | 1 | program counter load |
| pc_wdata | input | 16 | program counter load value |
| pc_inc | input | 1 | program counter increment |
| flag_we | input | 8 | status bit write mask |
| flag_wdata | input | 8 | status bit write data |
| a_q | output | 8 | accumulator |
| x_q | output | 8 | X register |
| y_q | output | 8 | Y register |
| ya_q | output | 16 | paired value {Y, A} |
| sp_q | output | 8 | stack pointer |
| pc_q | output | 16 | program counter, high byte then low byte |
| psw_q | output | 8 | status word |
| stk_addr | output | 16 | stack memory address |

## Verification
The stack pointer checks assume that it has been set by sp_load before the first push or pop. Until then its value is undefined. The bench therefore copies X into the pointer before any stack command. The priority-aware checks assume that commands meant to test one path do not overlap, unless the cycle is deliberately testing priority. The stimulus drives at most one conflicting command per cycle, except in the directed cases that exercise R5, R9 and R10.

// File: rtl/cpu_regs_pkg.sv
package cpu_regs_pkg;
  typedef enum logic [2:0] {
    IDX_NOP  = 3'd0,
    IDX_LOAD = 3'd1,
    IDX_INC  = 3'd2,
    IDX_DEC  = 3'd3,
    IDX_CMP  = 3'd4
  } idx_cmd_e;

  localparam int FLG_N = 7;
  localparam int FLG_V = 6;
  localparam int FLG_D = 5;
  localparam int FLG_B = 4;
  localparam int FLG_H = 3;
  localparam int FLG_I = 2;
  localparam int FLG_Z = 1;
  localparam int FLG_C = 0;
endpackage

// File: rtl/idx_reg.sv
module idx_reg #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [2:0]    cmd,
  input  logic [DW-1:0] opnd,
  input  logic          ovr_we,
  input  logic [DW-1:0] ovr_data,
  output logic [DW-1:0] q,
  output logic          cmp_v,
  output logic [2:0]    cmp_nzc
);
  import cpu_regs_pkg::*;

  idx_cmd_e    op;
  logic [DW:0] diff;

  assign op   = idx_cmd_e'(cmd);
  assign diff = {1'b0, q} - {1'b0, opnd};

  // R2: stepping wraps naturally at DW bits
  always_ff @(posedge clk) begin
    if (rst) begin
      q <= '0;
    end else if (ovr_we) begin
      q <= ovr_data;
    end else begin
      case (op)
        IDX_LOAD: q <= opnd;
        IDX_INC:  q <= q + 1'b1;
        IDX_DEC:  q <= q - 1'b1;
        default:  q <= q;
      endcase
    end
  end

  // R3: flags from the difference, register left alone
  assign cmp_v   = (op == IDX_CMP);
  assign cmp_nzc = {diff[DW-1], (diff[DW-1:0] == '0), ~diff[DW]};
endmodule

// File: rtl/stack_ptr.sv
module stack_ptr #(
  parameter int DW = 8,
  parameter int AW = 16
) (
  input  logic          clk,
  input  logic          ld,
  input  logic [DW-1:0] ld_data,
  input  logic          push,
  input  logic          pop,
  output logic [DW-1:0] sp,
  output logic [AW-1:0] addr
);
  localparam int PW = AW - DW;

  logic          pop_act;
  logic [DW-1:0] addr_lo;

  // R5: no reset; load beats push beats pop
  always_ff @(posedge clk) begin
    if (ld)        sp <= ld_data;
    else if (push) sp <= sp - 1'b1;
    else if (pop)  sp <= sp + 1'b1;
  end

  // R6/R7: push uses current slot, pop uses pre-incremented slot
  assign pop_act = pop && !push && !ld;
  assign addr_lo = pop_act ? sp + 1'b1 : sp;
  // R8: page byte fixed at zero
  assign addr    = {{PW{1'b0}}, addr_lo};
endmodule

// File: rtl/prog_counter.sv
module prog_counter #(
  parameter int          AW      = 16,
  parameter logic [15:0] RST_VEC = 16'hFFFE
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          ld,
  input  logic [AW-1:0] ld_data,
  input  logic          inc,
  output logic [AW-1:0] pc
);
  // R1, R10
  always_ff @(posedge clk) begin
    if (rst)      pc <= AW'(RST_VEC);
    else if (ld)  pc <= ld_data;
    else if (inc) pc <= pc + 1'b1;
  end
endmodule

// File: rtl/core_regfile.sv
module core_regfile #(
  parameter int          DW      = 8,
  parameter int          AW      = 16,
  parameter logic [15:0] RST_VEC = 16'hFFFE
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            a_we,
  input  logic [DW-1:0]   a_wdata,
  input  logic [2:0]      x_cmd,
  input  logic [DW-1:0]   x_opnd,
  input  logic [2:0]      y_cmd,
  input  logic [DW-1:0]   y_opnd,
  input  logic            ya_we,
  input  logic [2*DW-1:0] ya_wdata,
  input  logic            sp_load,
  input  logic            push,
  input  logic            pop,
  input  logic            pc_load,
  input  logic [AW-1:0]   pc_wdata,
  input  logic            pc_inc,
  input  logic [DW-1:0]   flag_we,
  input  logic [DW-1:0]   flag_wdata,
  output logic [DW-1:0]   a_q,
  output logic [DW-1:0]   x_q,
  output logic [DW-1:0]   y_q,
  output logic [2*DW-1:0] ya_q,
  output logic [DW-1:0]   sp_q,
  output logic [AW-1:0]   pc_q,
  output logic [DW-1:0]   psw_q,
  output logic [AW-1:0]   stk_addr
);
  import cpu_regs_pkg::*;

  localparam int NIDX = 2;

  logic [2:0]    cmd_v   [NIDX];
  logic [DW-1:0] opnd_v  [NIDX];
  logic          ovr_v   [NIDX];
  logic [DW-1:0] ovrd_v  [NIDX];
  logic [DW-1:0] q_v     [NIDX];
  logic          cmpv_v  [NIDX];
  logic [2:0]    nzc_v   [NIDX];
  logic [DW-1:0] psw_nxt;

  // slot 0 is X, slot 1 is Y (Y takes the high half of a paired write)
  assign cmd_v[0]  = x_cmd;
  assign opnd_v[0] = x_opnd;
  assign ovr_v[0]  = 1'b0;
  assign ovrd_v[0] = '0;
  assign cmd_v[1]  = y_cmd;
  assign opnd_v[1] = y_opnd;
  assign ovr_v[1]  = ya_we;
  assign ovrd_v[1] = ya_wdata[2*DW-1:DW];

  generate
    for (genvar gi = 0; gi < NIDX; gi++) begin : g_idx
      idx_reg #(.DW(DW)) u_idx (
        .clk      (clk),
        .rst      (rst),
        .cmd      (cmd_v[gi]),
        .opnd     (opnd_v[gi]),
        .ovr_we   (ovr_v[gi]),
        .ovr_data (ovrd_v[gi]),
        .q        (q_v[gi]),
        .cmp_v    (cmpv_v[gi]),
        .cmp_nzc  (nzc_v[gi])
      );
    end
  endgenerate

  assign x_q = q_v[0];
  assign y_q = q_v[1];

  // R9: paired write outranks single accumulator write
  always_ff @(posedge clk) begin
    if (rst)        a_q <= '0;
    else if (ya_we) a_q <= ya_wdata[DW-1:0];
    else if (a_we)  a_q <= a_wdata;
  end

  assign ya_q = {y_q, a_q};

  // R4/R3: masked flag write, then compare overrides N, Z, C
  always_comb begin
    psw_nxt = (psw_q & ~flag_we) | (flag_wdata & flag_we);
    if (cmpv_v[0]) begin
      psw_nxt[FLG_N] = nzc_v[0][2];
      psw_nxt[FLG_Z] = nzc_v[0][1];
      psw_nxt[FLG_C] = nzc_v[0][0];
    end else if (cmpv_v[1]) begin
      psw_nxt[FLG_N] = nzc_v[1][2];
      psw_nxt[FLG_Z] = nzc_v[1][1];
      psw_nxt[FLG_C] = nzc_v[1][0];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) psw_q <= '0;
    else     psw_q <= psw_nxt;
  end

  stack_ptr #(.DW(DW), .AW(AW)) u_sp (
    .clk     (clk),
    .ld      (sp_load),
    .ld_data (x_q),
    .push    (push),
    .pop     (pop),
    .sp      (sp_q),
    .addr    (stk_addr)
  );

  prog_counter #(.AW(AW), .RST_VEC(RST_VEC)) u_pc (
    .clk     (clk),
    .rst     (rst),
    .ld      (pc_load),
    .ld_data (pc_wdata),
    .inc     (pc_inc),
    .pc      (pc_q)
  );
endmodule

// File: rtl/core_regfile_chk.sv
module core_regfile_chk #(
  parameter int          DW      = 8,
  parameter int          AW      = 16,
  parameter logic [15:0] RST_VEC = 16'hFFFE
) (
  input logic            clk,
  input logic            rst,
  input logic [2:0]      x_cmd,
  input logic [DW-1:0]   x_q,
  input logic            ya_we,
  input logic [2*DW-1:0] ya_wdata,
  input logic [2*DW-1:0] ya_q,
  input logic            sp_load,
  input logic            push,
  input logic            pop,
  input logic [DW-1:0]   sp_q,
  input logic            pc_load,
  input logic            pc_inc,
  input logic [AW-1:0]   pc_q
);
  // R1
  reset_vector_chk: assert property (@(posedge clk)
    rst |=> (pc_q == AW'(RST_VEC)));

  // R2
  x_inc_step_chk: assert property (@(posedge clk) disable iff (rst)
    (x_cmd == 3'd2) |=> (x_q == DW'($past(x_q) + 1'b1)));

  // R3
  x_cmp_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (x_cmd == 3'd4) |=> (x_q == $past(x_q)));

  // R6
  push_down_chk: assert property (@(posedge clk) disable iff (rst)
    (push && !sp_load) |=> (sp_q == DW'($past(sp_q) - 1'b1)));

  // R7
  pop_up_chk: assert property (@(posedge clk) disable iff (rst)
    (pop && !push && !sp_load) |=> (sp_q == DW'($past(sp_q) + 1'b1)));

  // R9
  pair_write_chk: assert property (@(posedge clk) disable iff (rst)
    ya_we |=> (ya_q == $past(ya_wdata)));

  // R10
  pc_step_chk: assert property (@(posedge clk) disable iff (rst)
    (pc_inc && !pc_load) |=> (pc_q == AW'($past(pc_q) + 1'b1)));
endmodule

bind core_regfile core_regfile_chk #(.DW(DW), .AW(AW), .RST_VEC(RST_VEC)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .x_cmd    (x_cmd),
  .x_q      (x_q),
  .ya_we    (ya_we),
  .ya_wdata (ya_wdata),
  .ya_q     (ya_q),
  .sp_load  (sp_load),
  .push     (push),
  .pop      (pop),
  .sp_q     (sp_q),
  .pc_load  (pc_load),
  .pc_inc   (pc_inc),
  .pc_q     (pc_q)
);

// File: tb/sim_core_regfile.sv
`timescale 1ns/1ps
module sim_core_regfile;
  logic        clk = 1'b0;
  logic        rst;
  logic        a_we;
  logic [7:0]  a_wdata;
  logic [2:0]  x_cmd, y_cmd;
  logic [7:0]  x_opnd, y_opnd;
  logic        ya_we;
  logic [15:0] ya_wdata;
  logic        sp_load, push, pop;
  logic        pc_load, pc_inc;
  logic [15:0] pc_wdata;
  logic [7:0]  flag_we, flag_wdata;
  logic [7:0]  a_q, x_q, y_q, sp_q, psw_q;
  logic [15:0] ya_q, pc_q, stk_addr;

  int n_run = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  core_regfile u0 (
    .clk(clk), .rst(rst), .a_we(a_we), .a_wdata(a_wdata),
    .x_cmd(x_cmd), .x_opnd(x_opnd), .y_cmd(y_cmd), .y_opnd(y_opnd),
    .ya_we(ya_we), .ya_wdata(ya_wdata), .sp_load(sp_load), .push(push),
    .pop(pop), .pc_load(pc_load), .pc_wdata(pc_wdata), .pc_inc(pc_inc),
    .flag_we(flag_we), .flag_wdata(flag_wdata), .a_q(a_q), .x_q(x_q),
    .y_q(y_q), .ya_q(ya_q), .sp_q(sp_q), .pc_q(pc_q), .psw_q(psw_q),
    .stk_addr(stk_addr)
  );

  // compare table: {register, operand, expected {N,Z,C}}
  localparam logic [18:0] CMP_TAB [8] = '{
    {8'h80, 8'h80, 3'b011},
    {8'h10, 8'h20, 3'b100},
    {8'h20, 8'h10, 3'b001},
    {8'h00, 8'h01, 3'b100},
    {8'hFF, 8'h00, 3'b101},
    {8'h00, 8'h00, 3'b011},
    {8'h7F, 8'h80, 3'b100},
    {8'h90, 8'h10, 3'b101}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic idle();
    a_we = 0; a_wdata = 0; x_cmd = 0; x_opnd = 0; y_cmd = 0; y_opnd = 0;
    ya_we = 0; ya_wdata = 0; sp_load = 0; push = 0; pop = 0;
    pc_load = 0; pc_inc = 0; pc_wdata = 0; flag_we = 0; flag_wdata = 0;
  endtask

  // one rising edge, returns at the following falling edge
  task automatic cyc();
    @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual timeout expected finish");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    idle();
    rst = 1;
    @(negedge clk); cyc(); cyc();
    // R1 reset state
    chk("R1 pc", pc_q, 32'hFFFE);
    chk("R1 a", a_q, 0);
    chk("R1 x", x_q, 0);
    chk("R1 y", y_q, 0);
    chk("R1 psw", psw_q, 0);
    rst = 0;
    cyc();

    // R3 compare table walk
    for (int i = 0; i < 8; i++) begin
      x_cmd = 3'd1; x_opnd = CMP_TAB[i][18:11]; cyc();
      x_cmd = 3'd4; x_opnd = CMP_TAB[i][10:3];  cyc();
      x_cmd = 3'd0;
      chk("R3 nzc", {psw_q[7], psw_q[1], psw_q[0]}, CMP_TAB[i][2:0]);
      chk("R3 x unchanged", x_q, CMP_TAB[i][18:11]);
    end

    // R2 wrap
    x_cmd = 3'd1; x_opnd = 8'hFF; cyc();
    x_cmd = 3'd2; cyc(); chk("R2 x inc wrap", x_q, 8'h00);
    x_cmd = 3'd3; cyc(); chk("R2 x dec wrap", x_q, 8'hFF);
    x_cmd = 3'd0;
    y_cmd = 3'd3; cyc(); chk("R2 y dec wrap", y_q, 8'hFF);
    // Y compare FF vs 01: N1 Z0 C1
    y_cmd = 3'd4; y_opnd = 8'h01; cyc(); y_cmd = 0;
    chk("R3 y cmp", {psw_q[7], psw_q[1], psw_q[0]}, 3'b101);
    // both compare: X equal wins
    x_cmd = 3'd1; x_opnd = 8'h05; cyc();
    x_cmd = 3'd4; x_opnd = 8'h05; y_cmd = 3'd4; y_opnd = 8'h01; cyc();
    x_cmd = 0; y_cmd = 0;
    chk("R3 x over y", {psw_q[7], psw_q[1], psw_q[0]}, 3'b011);

    // R4 flag port
    flag_we = 8'hFF; flag_wdata = 8'h00; cyc();
    chk("R4 clear", psw_q, 8'h00);
    flag_we = 8'h40; flag_wdata = 8'hFF; cyc();
    chk("R4 mask V", psw_q, 8'h40);
    flag_we = 8'h02; flag_wdata = 8'h00; x_cmd = 3'd4; x_opnd = 8'h05; cyc();
    flag_we = 0; x_cmd = 0;
    chk("R4 cmp overrides", psw_q, 8'h43);

    // R5 stack pointer from X
    x_cmd = 3'd1; x_opnd = 8'h02; cyc(); x_cmd = 0;
    sp_load = 1; cyc(); sp_load = 0;
    chk("R5 sp load", sp_q, 8'h02);
    // R6 push
    push = 1; #1;
    chk("R6 push addr", stk_addr, 16'h0002);
    cyc(); chk("R6 sp dec", sp_q, 8'h01);
    cyc(); chk("R6 sp dec", sp_q, 8'h00);
    #1; chk("R8 page", stk_addr[15:8], 0);
    chk("R6 push addr zero", stk_addr, 16'h0000);
    cyc(); push = 0;
    chk("R6 wrap", sp_q, 8'hFF);
    // R7 pop from FF
    pop = 1; #1;
    chk("R7 pop addr wrap", stk_addr, 16'h0000);
    cyc(); pop = 0;
    chk("R7 sp inc wrap", sp_q, 8'h00);
    pop = 1; #1;
    chk("R7 pop addr", stk_addr, 16'h0001);
    chk("R8 page", stk_addr[15:8], 0);
    cyc(); pop = 0;
    chk("R7 sp inc", sp_q, 8'h01);
    // R5 priority
    push = 1; pop = 1; cyc(); push = 0; pop = 0;
    chk("R5 push over pop", sp_q, 8'h00);
    sp_load = 1; push = 1; cyc(); sp_load = 0; push = 0;
    chk("R5 load over push", sp_q, 8'h02);

    // R9 paired access
    ya_we = 1; ya_wdata = 16'h1234; a_we = 1; a_wdata = 8'hAA;
    y_cmd = 3'd1; y_opnd = 8'hBB; cyc();
    ya_we = 0; a_we = 0; y_cmd = 0;
    chk("R9 a low", a_q, 8'h34);
    chk("R9 y high", y_q, 8'h12);
    chk("R9 pair", ya_q, 16'h1234);
    a_we = 1; a_wdata = 8'h56; cyc(); a_we = 0;
    chk("R9 a alone", ya_q, 16'h1256);
    y_cmd = 3'd1; y_opnd = 8'h9A; cyc(); y_cmd = 0;
    chk("R9 y alone", ya_q, 16'h9A56);

    // R10 program counter
    pc_load = 1; pc_wdata = 16'hABCD; cyc(); pc_load = 0;
    chk("R10 load", pc_q, 16'hABCD);
    pc_inc = 1; cyc(); pc_inc = 0;
    chk("R10 inc", pc_q, 16'hABCE);
    pc_load = 1; pc_wdata = 16'hFFFF; cyc(); pc_load = 0;
    pc_inc = 1; cyc(); pc_inc = 0;
    chk("R10 wrap", pc_q, 16'h0000);
    pc_load = 1; pc_inc = 1; pc_wdata = 16'h1000; cyc();
    pc_load = 0; pc_inc = 0;
    chk("R10 load over inc", pc_q, 16'h1000);

    // R1 reset mid-run
    rst = 1; cyc(); rst = 0;
    chk("R1 pc again", pc_q, 32'hFFFE);
    chk("R1 ya again", ya_q, 0);
    cyc();

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule